// File: doc/BRIEF.md
# Floating-Point Error Interrupt Glue

This block connects a processor's active-low floating-point error output to a PC/AT-style system interrupt controller. An unmasked numeric exception makes the processor drive its error line low and stall until it is told to carry on. The block first passes that line through a two-stage synchronizer. It then raises a level interrupt request, and the interrupt controller turns that request into the processor's INTR.

The interrupt service routine answers with an I/O write to the fixed acknowledge port (0xF0). That write drives the active-low ignore-numeric-error input of the processor low and drops the interrupt request. With the ignore input low, the processor resumes execution. The ignore input stays low as long as the error line stays asserted. It is released once the processor withdraws the error. After that release, a fresh error raises the request again.

Top module: `fperr_irq_glue`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `irq` is 0 and `ignore_n` is 1.
- R2: When `err_n` goes low and stays low, `irq` goes to 1 at the third rising edge after the fall, counted from the first edge that sees `err_n` low. It is 0 before that edge. It stays 1 until an acknowledge write or until the error is withdrawn.
- R3: With the synchronized error asserted, a rising edge that sees `io_wr`=1 and `io_addr`=0x00F0 drives `ignore_n` to 0 and `irq` to 0 at that same edge.
- R4: Once `ignore_n` is 0, it stays 0 and `irq` stays 0 for as long as `err_n` stays low.
- R5: After `err_n` returns high, `ignore_n` returns to 1 at the third rising edge that sees `err_n` high.
- R6: An acknowledge write (0xF0) made while the synchronized error is negated changes neither `ignore_n` nor `irq`. A later error still raises `irq`.
- R7: The address decode is full-width. A write to any address other than 0x00F0 is ignored, including addresses that match only in the low byte. A cycle with `io_wr`=0 is ignored whatever its address.
- R8: If the error is withdrawn without an acknowledge, `irq` falls to 0 at the third rising edge that sees `err_n` high.
- R9: A new error that follows a full negation raises `irq` again, with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_n | input | 1 | Floating-point error from the processor, active low, asynchronous |
| io_addr | input | ADDR_W | I/O cycle address |
| io_wr | input | 1 | I/O write strobe, sampled at the rising edge |
| ignore_n | output | 1 | Ignore-numeric-error input to the processor, active low |
| irq | output | 1 | Level interrupt request to the interrupt controller |

## Verification
The block holds only two stored bits besides the synchronizer: the pending request and the held ignore state. Any error in either bit appears at `irq` or `ignore_n` within one edge of the stimulus that should have set or cleared it. A synchronizer that is too short or too long moves the R2, R5 and R8 transitions off the third edge. The bench checks the output one edge early and at the exact edge, so it catches such a shift. A decode error shows up when the bench sweeps the write address with the error held. Under that sweep, only 0x00F0 may clear `irq` and drive `ignore_n` low.

// File: rtl/fperr_irq_glue.sv
module fperr_irq_glue #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ACK_PORT = 'h00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  output logic              ignore_n,
  output logic              irq
);

  logic err_meta, err_sync;
  logic ign_q, irq_q;
  logic ack_hit;

  assign ack_hit = io_wr && (io_addr == ACK_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_meta <= 1'b0;
      err_sync <= 1'b0;
    end else begin
      err_meta <= ~err_n;
      err_sync <= err_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ign_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ign_q <= err_sync && (ign_q || ack_hit);
      irq_q <= err_sync && !ign_q && !ack_hit;
    end
  end

  assign ignore_n = ~ign_q;
  assign irq      = irq_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!irq_q && !ign_q));

  // R3
  ign_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ign_q) |-> $past(ack_hit));

  // R4
  req_ign_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && ign_q));

  // R4
  ign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ign_q && err_sync) |=> ign_q);

  // R5
  ign_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ign_q && !err_sync) |=> !ign_q);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && err_sync && !ack_hit) |=> irq_q);

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !err_sync |=> !irq_q);

endmodule

// File: tb/fperr_irq_glue_test.sv
module fperr_irq_glue_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_n = 1'b1;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 1'b0;
  logic ignore_n, irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fperr_irq_glue #(.ADDR_W(AW), .ACK_PORT(16'h00F0)) uut (
    .clk(clk), .rst(rst), .err_n(err_n), .io_addr(io_addr),
    .io_wr(io_wr), .ignore_n(ignore_n), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act_irq, input logic act_ign,
                     input logic exp_irq, input logic exp_ign);
    n_run++;
    if (act_irq !== exp_irq || act_ign !== exp_ign) begin
      n_fail++;
      $display("FAIL %s: irq=%b ignore_n=%b expected irq=%b ignore_n=%b",
               req, act_irq, act_ign, exp_irq, exp_ign);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; err_n = 1'b1; io_wr = 1'b0; io_addr = '0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic write(input logic [AW-1:0] a, input logic wr);
    io_addr = a; io_wr = wr;
    tick(1);
    io_wr = 1'b0; io_addr = '0;
  endtask

  task automatic raise_err(input string req);
    err_n = 1'b0;
    tick(2);
    chk(req, irq, ignore_n, 1'b0, 1'b1);
    tick(1);
    chk(req, irq, ignore_n, 1'b1, 1'b1);
  endtask

  initial begin
    tick(1);
    do_reset();
    // R1
    chk("R1", irq, ignore_n, 1'b0, 1'b1);

    // R2
    raise_err("R2");
    tick(5);
    chk("R2", irq, ignore_n, 1'b1, 1'b1);

    // R3
    write(16'h00F0, 1'b1);
    chk("R3", irq, ignore_n, 1'b0, 1'b0);
    // R4
    tick(10);
    chk("R4", irq, ignore_n, 1'b0, 1'b0);
    write(16'h00F0, 1'b1);
    chk("R4", irq, ignore_n, 1'b0, 1'b0);

    // R5
    err_n = 1'b1;
    tick(2);
    chk("R5", irq, ignore_n, 1'b0, 1'b0);
    tick(1);
    chk("R5", irq, ignore_n, 1'b0, 1'b1);

    // R6
    write(16'h00F0, 1'b1);
    chk("R6", irq, ignore_n, 1'b0, 1'b1);
    tick(3);
    chk("R6", irq, ignore_n, 1'b0, 1'b1);

    // R9
    raise_err("R9");

    // R8
    err_n = 1'b1;
    tick(2);
    chk("R8", irq, ignore_n, 1'b1, 1'b1);
    tick(1);
    chk("R8", irq, ignore_n, 1'b0, 1'b1);

    // R7
    raise_err("R7");
    write(16'h00F0, 1'b0);
    chk("R7", irq, ignore_n, 1'b1, 1'b1);
    write(16'h01F0, 1'b1);
    chk("R7", irq, ignore_n, 1'b1, 1'b1);
    write(16'hF0F0, 1'b1);
    chk("R7", irq, ignore_n, 1'b1, 1'b1);

    // R7 / R3
    for (int a = 0; a < 256; a++) begin
      logic hit;
      do_reset();
      raise_err("R2");
      write(AW'(a), 1'b1);
      hit = (a == 'hF0);
      chk(hit ? "R3" : "R7", irq, ignore_n, !hit, !hit);
      err_n = 1'b1;
      tick(3);
      chk(hit ? "R5" : "R8", irq, ignore_n, 1'b0, 1'b1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule